// File: doc/BRIEF.md
# Lock-Qualified Shared Bus Arbiter

This block decides which of two masters owns a shared memory bus: the processor port, or one external agent such as a DMA engine. The external agent raises a hold request. The arbiter answers it with a hold acknowledge once the processor has released the bus. The processor raises a lock flag to mark an atomic read-modify-write or an indivisible multi-beat transfer. While that flag is high, a pending hold request waits. This keeps any sequence that stays inside one aligned 16-byte block from being split by the other master.

The processor asks to start a bus cycle with `cpu_req` and may begin only in a cycle where `cpu_gnt` is high. It reports the end of each cycle with `cpu_done`. After a hold acknowledge, the processor side stays parked until the agent withdraws its request. The agent's own access is therefore never pre-empted. When a locked start is accepted, the block also compares its start address and byte count against the block boundary. It flags any locked access that would cross that boundary.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While `rst` is high at a rising edge, the internal state is cleared. After reset, `ext_hlda` and `lock_err` read 0 and, with `ext_hold` low, `cpu_gnt` reads 1.
- R2: While the bus is not acknowledged to the agent and `ext_hold` is low, `cpu_gnt` is 1 in the same cycle, whether `cpu_lock` is high or low. A locked sequence therefore sees no arbitration delay.
- R3: While `cpu_lock` is high and `ext_hlda` is low, `ext_hlda` stays low at the next edge, even with `ext_hold` high. The request stays pending.
- R4: Suppose a processor cycle is in progress, `cpu_lock` is low and `ext_hold` is high. `ext_hlda` rises at the edge that samples `cpu_done` high, and not earlier.
- R5: If `ext_hold` is high, `cpu_lock` is low and no processor cycle is in progress, `ext_hlda` rises at the next edge.
- R6: While `ext_hlda` is 1, `cpu_gnt` is 0, whatever `cpu_req` and `cpu_lock` show.
- R7: While `ext_hlda` is 1, sampling `ext_hold` low at an edge clears `ext_hlda` at that edge, and `cpu_gnt` returns in the same cycle.
- R8: In a cycle where the hold would be granted (R5), `cpu_gnt` is already 0, so an unlocked processor request in that cycle does not start.
- R9: When a locked start is accepted whose first and last byte lie in different aligned 16-byte blocks, `lock_err` is 1 for exactly the following cycle. That is the case when address bits [3:0] plus the byte count exceed 16. A locked start that ends exactly on the boundary gives no error.
- R10: An accepted start with `cpu_lock` low never raises `lock_err`, even when it crosses a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor wants to start a bus cycle this clock |
| cpu_lock | input | 1 | Processor lock flag for atomic or indivisible sequences |
| cpu_addr | input | AW | Start byte address of the requested access |
| cpu_size | input | SZ_W | Byte count of the access (1 to 16) |
| cpu_done | input | 1 | Current processor bus cycle completes this clock |
| cpu_gnt | output | 1 | Processor may start a bus cycle this clock |
| ext_hold | input | 1 | Hold request from the external agent |
| ext_hlda | output | 1 | Hold acknowledge to the external agent |
| lock_err | output | 1 | One-cycle flag: a locked access crossed a 16-byte block |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and a 16-byte block. With these defaults the offsets 0 to 15 and the byte counts 1 to 16 are all reachable. The boundary cases it drives are an access that ends exactly on the block edge, one that crosses it, and an unlocked crossing. It also drives a hold request held off by a lock and then released through a cycle completion. Finally it drives a tie between a fresh hold and a processor request in the same cycle.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_EXT = 1'b1
    } owner_e;

    typedef struct packed {
        logic start;
        logic locked;
        logic done;
    } cpu_evt_t;

endpackage

// File: rtl/sba_cycle_track.sv
module sba_cycle_track
    import sba_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_evt_t evt,
    output logic     busy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (evt.start) begin
            busy <= 1'b1;
        end else if (evt.done) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/sba_span_check.sv
module sba_span_check #(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 16,
    localparam int OFS_W    = $clog2(BLK_BYTES),
    localparam int SZ_W     = OFS_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            check_en,
    input  logic [AW-1:0]   addr,
    input  logic [SZ_W-1:0] size,
    output logic            err
);

    logic [AW-1:0] last_byte;
    logic          crosses;

    always_comb begin
        last_byte = addr + AW'(size) - AW'(1);
        crosses   = (size != '0) &&
                    (addr[AW-1:OFS_W] != last_byte[AW-1:OFS_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else begin
            err <= check_en && crosses;
        end
    end

endmodule

// File: rtl/sba_grant_fsm.sv
module sba_grant_fsm
    import sba_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_hold,
    input  logic cpu_lock,
    input  logic cyc_busy,
    input  logic cyc_done,
    output logic cpu_gnt,
    output logic ext_hlda
);

    owner_e owner_q;
    owner_e owner_d;
    logic   cpu_quiet;
    logic   hand_over;

    always_comb begin
        cpu_quiet = !cyc_busy || cyc_done;
        hand_over = (owner_q == OWN_CPU) && ext_hold && !cpu_lock && cpu_quiet;
        cpu_gnt   = (owner_q == OWN_CPU) && !hand_over;
        owner_d   = owner_q;
        case (owner_q)
            OWN_CPU: if (hand_over) owner_d = OWN_EXT;
            OWN_EXT: if (!ext_hold) owner_d = OWN_CPU;
            default: owner_d = OWN_CPU;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_CPU;
        end else begin
            owner_q <= owner_d;
        end
    end

    assign ext_hlda = (owner_q == OWN_EXT);

endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
    import sba_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BLK_BYTES = 16,
    localparam int OFS_W    = $clog2(BLK_BYTES),
    localparam int SZ_W     = OFS_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cpu_req,
    input  logic            cpu_lock,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [SZ_W-1:0] cpu_size,
    input  logic            cpu_done,
    output logic            cpu_gnt,
    input  logic            ext_hold,
    output logic            ext_hlda,
    output logic            lock_err
);

    cpu_evt_t evt;
    logic     cyc_busy;

    always_comb begin
        evt.start  = cpu_req && cpu_gnt;
        evt.locked = cpu_lock;
        evt.done   = cpu_done;
    end

    sba_cycle_track i_track (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .busy (cyc_busy)
    );

    sba_grant_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .ext_hold (ext_hold),
        .cpu_lock (cpu_lock),
        .cyc_busy (cyc_busy),
        .cyc_done (cpu_done),
        .cpu_gnt  (cpu_gnt),
        .ext_hlda (ext_hlda)
    );

    sba_span_check #(
        .AW        (AW),
        .BLK_BYTES (BLK_BYTES)
    ) i_span (
        .clk      (clk),
        .rst      (rst),
        .check_en (evt.start && evt.locked),
        .addr     (cpu_addr),
        .size     (cpu_size),
        .err      (lock_err)
    );

endmodule

// File: rtl/sba_checker.sv
module sba_checker (
    input logic clk,
    input logic rst,
    input logic cpu_req,
    input logic cpu_lock,
    input logic cpu_gnt,
    input logic ext_hold,
    input logic ext_hlda,
    input logic lock_err,
    input logic cyc_busy
);

    a_r2_free_grant: assert property (@(posedge clk) disable iff (rst)
        (!ext_hold && !ext_hlda) |-> cpu_gnt);

    a_r3_lock_defers: assert property (@(posedge clk) disable iff (rst)
        (cpu_lock && !ext_hlda) |=> !ext_hlda);

    a_r4_ack_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_hlda) |-> ($past(ext_hold) && !$past(cpu_lock)));

    a_r5_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (ext_hold && !cpu_lock && !cyc_busy && !ext_hlda) |=> ext_hlda);

    a_r6_parked: assert property (@(posedge clk) disable iff (rst)
        ext_hlda |-> !cpu_gnt);

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (ext_hlda && !ext_hold) |=> !ext_hlda);

    a_r9_err_source: assert property (@(posedge clk) disable iff (rst)
        lock_err |-> $past(cpu_req && cpu_lock && cpu_gnt));

endmodule

bind shared_bus_arbiter sba_checker i_sba_checker (
    .clk      (clk),
    .rst      (rst),
    .cpu_req  (cpu_req),
    .cpu_lock (cpu_lock),
    .cpu_gnt  (cpu_gnt),
    .ext_hold (ext_hold),
    .ext_hlda (ext_hlda),
    .lock_err (lock_err),
    .cyc_busy (cyc_busy)
);

// File: tb/test_shared_bus_arbiter.sv
module test_shared_bus_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic          cpu_lock = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [4:0]    cpu_size = 5'd4;
    logic          cpu_done = 1'b0;
    logic          cpu_gnt;
    logic          ext_hold = 1'b0;
    logic          ext_hlda;
    logic          lock_err;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_bus_arbiter i_shared_bus_arbiter (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_lock(cpu_lock),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_done(cpu_done),
        .cpu_gnt(cpu_gnt), .ext_hold(ext_hold), .ext_hlda(ext_hlda),
        .lock_err(lock_err)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_cycle(input logic lk, input logic [AW-1:0] a, input logic [4:0] s);
        cpu_req = 1'b1; cpu_lock = lk; cpu_addr = a; cpu_size = s;
        tick();
        cpu_req = 1'b0;
    endtask

    task automatic finish_cycle();
        cpu_done = 1'b1;
        tick();
        cpu_done = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        #1;
        chk("R1 hlda after reset", ext_hlda, 1'b0);
        chk("R1 err after reset", lock_err, 1'b0);
        chk("R1 gnt after reset", cpu_gnt, 1'b1);
    endtask

    task automatic t_free_locked();
        cpu_req = 1'b1; cpu_lock = 1'b1; cpu_addr = 32'h100; cpu_size = 5'd16;
        #1;
        chk("R2 locked gnt with no hold", cpu_gnt, 1'b1);
        tick();
        cpu_req = 1'b0;
        chk("R9 aligned 16-byte locked no err", lock_err, 1'b0);
        finish_cycle();
        cpu_lock = 1'b0;
        tick();
    endtask

    task automatic t_hold_during_lock();
        start_cycle(1'b1, 32'h200, 5'd8);
        ext_hold = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 hold deferred by lock", ext_hlda, 1'b0);
        end
        finish_cycle();
        chk("R3 done but still locked", ext_hlda, 1'b0);
        cpu_lock = 1'b0;
        #1;
        chk("R8 gnt withheld at hand-over", cpu_gnt, 1'b0);
        tick();
        chk("R5 ack after lock release", ext_hlda, 1'b1);
        cpu_req = 1'b1; cpu_lock = 1'b1;
        #1;
        chk("R6 no gnt while acknowledged", cpu_gnt, 1'b0);
        tick();
        chk("R6 lock ignored, hlda kept", ext_hlda, 1'b1);
        chk("R6 no start, no err", lock_err, 1'b0);
        cpu_req = 1'b0; cpu_lock = 1'b0;
        ext_hold = 1'b0;
        tick();
        chk("R7 hlda drops", ext_hlda, 1'b0);
        chk("R7 gnt returns", cpu_gnt, 1'b1);
    endtask

    task automatic t_ack_on_done();
        start_cycle(1'b0, 32'h300, 5'd4);
        ext_hold = 1'b1;
        tick();
        chk("R4 no ack while cycle runs", ext_hlda, 1'b0);
        cpu_done = 1'b1;
        tick();
        cpu_done = 1'b0;
        chk("R4 ack at done edge", ext_hlda, 1'b1);
        ext_hold = 1'b0;
        tick();
        chk("R7 release after done case", ext_hlda, 1'b0);
    endtask

    task automatic t_tie();
        ext_hold = 1'b1; cpu_req = 1'b1; cpu_lock = 1'b0;
        #1;
        chk("R8 tie gives no gnt", cpu_gnt, 1'b0);
        tick();
        cpu_req = 1'b0;
        chk("R5 idle ack next edge", ext_hlda, 1'b1);
        ext_hold = 1'b0;
        tick();
        chk("R7 tie release", ext_hlda, 1'b0);
    endtask

    task automatic t_span();
        start_cycle(1'b1, 32'h40C, 5'd8);
        chk("R9 locked crossing err", lock_err, 1'b1);
        finish_cycle();
        chk("R9 err lasts one cycle", lock_err, 1'b0);
        start_cycle(1'b1, 32'h40C, 5'd4);
        chk("R9 ends on boundary no err", lock_err, 1'b0);
        finish_cycle();
        start_cycle(1'b1, 32'h40F, 5'd2);
        chk("R9 last-byte crossing err", lock_err, 1'b1);
        finish_cycle();
        start_cycle(1'b0, 32'h40F, 5'd2);
        chk("R10 unlocked crossing no err", lock_err, 1'b0);
        finish_cycle();
        cpu_lock = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_free_locked();
        t_hold_during_lock();
        t_ack_on_done();
        t_tie();
        t_span();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule